// File: doc/BRIEF.md
# Filtered Event Counter Bank with Overflow Interrupt

This block holds a bank of programmable hardware event counters for a processor hart. Counter slots 0 to 2 are reserved for the fixed cycle, time and retired-instruction counters and are not implemented here. The programmable counters occupy indices 3 to 2+NPROG. Each programmable counter has a 64-bit count register and a 64-bit event-control register. Event input bit i is a one-cycle pulse, and it advances counter 3+i.

An increment is skipped in two cases: the counter's bit in a global count-inhibit register is set, or one of the counter's mode-inhibit bits matches the current privilege level and virtualization state. When a counter wraps, it sets a sticky overflow flag in its event-control register. If that flag was clear before the wrap, the block also sets a bit in a pending register. The interrupt output is the OR of the pending register.

The bank runs in either a 64-bit register mode or a 32-bit register mode. In 32-bit mode, software reaches each 64-bit register as a low half and a high half. All registers are reached through one register port. Writes take effect at the clock edge and reads are combinational.

Top module: `perf_event_bank`

## Requirements
- R1: After reset, every counter, event-control register, the count-inhibit register and the pending register read zero, and `lcof_irq` is low.
- R2: A pulse on `evt[i]` advances counter 3+i by exactly one at the next clock edge. Without a pulse or a register write, the counter holds its value.
- R3: While count-inhibit bit k is set, counter k does not advance. The count-inhibit register uses sel 4, and bit k stands for counter k. Its bits below 3 and above 2+NPROG read zero.
- R4: With `virt` low, an event is dropped in each of these cases: privilege is M (`priv`=3) and bit 62 of the event-control register is set; privilege is S (`priv`=1) and bit 61 is set; privilege is U (`priv`=0) and bit 60 is set.
- R5: With `virt` high, S uses bit 59 and U uses bit 58 in place of bits 61 and 60. M still uses bit 62, whatever the value of `virt`.
- R6: In 64-bit mode (`half_mode`=0), a counter holding all ones becomes zero on its next event.
- R7: In 32-bit mode (`half_mode`=1), an event advances the low half while the low half is not all ones. If the low half is all ones, the event advances the high half and the low half stays all ones. If both halves are all ones, both become zero, which is an overflow.
- R8: On an overflow while the flag (event-control bit 63) is clear, bit 63 is set, pending bit 3+i is set, and `lcof_irq` goes high.
- R9: On an overflow while bit 63 is already set, the counter still wraps, but no pending bit is set.
- R10: Writing a one to bit k of the pending register (sel 5) clears pending bit k. The overflow flag is cleared only by a register write that puts a zero in it.
- R11: A register write to a counter's count or event-control register in the same cycle as that counter's event takes effect, and the event is dropped.
- R12: Writes to count or event-control sels with an index outside 3 to 2+NPROG change nothing, and reads at such an index return zero.
- R13: Register sels: 0 is count low, 1 is count high, 2 is event low and 3 is event high. In 64-bit mode, sel 0 and sel 2 access the full 64 bits, and writes to sel 1 and sel 3 are ignored. In 32-bit mode, sel 0 and sel 2 access bits 31:0, and sel 1 and sel 3 access bits 63:32 on `csr_wdata[31:0]`/`csr_rdata[31:0]`. This places the flag at bit 31 and the M/S/U/VS/VU inhibit bits at bits 30/29/28/27/26 of the high event register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| half_mode | input | 1 | 1: 32-bit register mode, 0: 64-bit register mode |
| priv | input | 2 | Current privilege: 0 U, 1 S, 3 M |
| virt | input | 1 | Virtualization active |
| evt | input | NPROG | One-cycle event pulses, bit i for counter 3+i |
| csr_we | input | 1 | Register write strobe |
| csr_sel | input | 3 | Register kind select |
| csr_idx | input | 5 | Counter index for sels 0 to 3 |
| csr_wdata | input | 64 | Write data |
| csr_rdata | output | 64 | Read data for the current sel and index |
| lcof_irq | output | 1 | Counter-overflow interrupt request |

## Verification
The hardest situation to reach from the ports is a wrap. A counter driven only by events would need 2^64 pulses to get there. The bench instead loads the count to one or two steps below all ones through the register port, and then applies single pulses. The same method reaches the 32-bit case: the low half is saturated and the high half is loaded to all ones. That is the only way to see the low half hold while the high half advances. The second-overflow case leaves the flag set, clears only the pending bit, and wraps again, which shows that no new request follows.

// File: rtl/perf_event_bank.sv
module perf_event_bank #(
  parameter int NPROG = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             half_mode,
  input  logic [1:0]       priv,
  input  logic             virt,
  input  logic [NPROG-1:0] evt,
  input  logic             csr_we,
  input  logic [2:0]       csr_sel,
  input  logic [4:0]       csr_idx,
  input  logic [63:0]      csr_wdata,
  output logic [63:0]      csr_rdata,
  output logic             lcof_irq
);
  localparam int FIRST = 3;
  localparam int FLAG_B = 63;
  localparam int MI_B = 62, SI_B = 61, UI_B = 60, VSI_B = 59, VUI_B = 58;
  localparam logic [2:0] S_CLO = 3'd0, S_CHI = 3'd1, S_ELO = 3'd2,
                         S_EHI = 3'd3, S_INH = 3'd4, S_PND = 3'd5;

  logic [63:0]      cnt [NPROG];
  logic [63:0]      ev  [NPROG];
  logic [NPROG-1:0] inh_q, pend_q, pend_set;

  for (genvar i = 0; i < NPROG; i++) begin : g_ctr
    logic [63:0] c_q, e_q, c_nxt;
    logic hit, m_inh, go, ovf;

    assign hit   = csr_we && (csr_idx == 5'(FIRST + i)) && (csr_sel <= S_EHI);
    assign m_inh = (priv == 2'b11) ? e_q[MI_B] :
                   (priv == 2'b01) ? (virt ? e_q[VSI_B] : e_q[SI_B]) :
                   (priv == 2'b00) ? (virt ? e_q[VUI_B] : e_q[UI_B]) : 1'b0;
    assign go    = evt[i] && !inh_q[i] && !m_inh && !hit;
    assign ovf   = go && (&c_q);
    assign c_nxt = (half_mode && (&c_q[31:0]) && !(&c_q[63:32]))
                   ? {c_q[63:32] + 32'd1, c_q[31:0]} : c_q + 64'd1;
    assign pend_set[i] = ovf && !e_q[FLAG_B];
    assign cnt[i] = c_q;
    assign ev[i]  = e_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        c_q <= '0;
        e_q <= '0;
      end else begin
        if (hit && csr_sel == S_CLO) begin
          if (half_mode) c_q[31:0] <= csr_wdata[31:0];
          else           c_q <= csr_wdata;
        end else if (hit && csr_sel == S_CHI) begin
          if (half_mode) c_q[63:32] <= csr_wdata[31:0];
        end else if (go) begin
          c_q <= c_nxt;
        end

        if (hit && csr_sel == S_ELO) begin
          if (half_mode) e_q[31:0] <= csr_wdata[31:0];
          else           e_q <= csr_wdata;
        end else if (hit && csr_sel == S_EHI) begin
          if (half_mode) e_q[63:32] <= csr_wdata[31:0];
        end else if (ovf) begin
          e_q[FLAG_B] <= 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      inh_q  <= '0;
      pend_q <= '0;
    end else begin
      if (csr_we && csr_sel == S_INH) inh_q <= csr_wdata[FIRST +: NPROG];
      if (csr_we && csr_sel == S_PND)
        pend_q <= (pend_q & ~csr_wdata[FIRST +: NPROG]) | pend_set;
      else
        pend_q <= pend_q | pend_set;
    end
  end

  always_comb begin
    csr_rdata = '0;
    case (csr_sel)
      S_INH: csr_rdata = 64'(inh_q) << FIRST;
      S_PND: csr_rdata = 64'(pend_q) << FIRST;
      default:
        for (int i = 0; i < NPROG; i++) begin
          if (csr_idx == 5'(FIRST + i)) begin
            case (csr_sel)
              S_CLO: csr_rdata = half_mode ? {32'b0, cnt[i][31:0]} : cnt[i];
              S_CHI: csr_rdata = half_mode ? {32'b0, cnt[i][63:32]} : '0;
              S_ELO: csr_rdata = half_mode ? {32'b0, ev[i][31:0]} : ev[i];
              S_EHI: csr_rdata = half_mode ? {32'b0, ev[i][63:32]} : '0;
              default: csr_rdata = '0;
            endcase
          end
        end
    endcase
  end

  assign lcof_irq = |pend_q;
endmodule

module perf_event_bank_chk #(
  parameter int NPROG = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic [NPROG-1:0] evt,
  input logic             csr_we,
  input logic [63:0]      cnt [NPROG],
  input logic [63:0]      ev  [NPROG],
  input logic [NPROG-1:0] inh_q,
  input logic [NPROG-1:0] pend_q
);
  for (genvar i = 0; i < NPROG; i++) begin : g_chk
    p_count_needs_cause_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!evt[i] && !csr_we) |=> $stable(cnt[i]));
    p_inhibit_holds_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (inh_q[i] && !csr_we) |=> $stable(cnt[i]));
    p_pend_rise_sets_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pend_q[i]) |-> ev[i][63]);
    p_no_new_irq_when_flagged_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pend_q[i]) |-> !$past(ev[i][63]));
    p_flag_clear_by_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ev[i][63]) |-> $past(csr_we));
    p_pend_clear_by_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(pend_q[i]) |-> $past(csr_we));
  end
endmodule

bind perf_event_bank perf_event_bank_chk #(.NPROG(NPROG)) u_chk (
  .clk(clk), .rst_n(rst_n), .evt(evt), .csr_we(csr_we),
  .cnt(cnt), .ev(ev), .inh_q(inh_q), .pend_q(pend_q)
);

// File: tb/test_perf_event_bank.sv
module test_perf_event_bank;
  localparam int CLK_P = 10;
  localparam int NPROG = 4;
  localparam logic [63:0] ONES = '1;

  logic clk = 0, rst_n = 0, half_mode = 0, virt = 0, csr_we = 0, lcof_irq;
  logic [1:0] priv = 2'b11;
  logic [NPROG-1:0] evt = '0;
  logic [2:0] csr_sel = 0;
  logic [4:0] csr_idx = 0;
  logic [63:0] csr_wdata = 0, csr_rdata;
  int total = 0, bad = 0;
  bit done = 0;

  perf_event_bank #(.NPROG(NPROG)) i_perf_event_bank (.*);

  always #(CLK_P/2) clk = ~clk;

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] sel, logic [4:0] idx, logic [63:0] d);
    @(negedge clk);
    csr_we = 1; csr_sel = sel; csr_idx = idx; csr_wdata = d;
    @(negedge clk);
    csr_we = 0;
  endtask

  task automatic rd(logic [2:0] sel, logic [4:0] idx, output logic [63:0] v);
    csr_sel = sel; csr_idx = idx;
    #1 v = csr_rdata;
  endtask

  task automatic pulse(logic [NPROG-1:0] m);
    @(negedge clk); evt = m;
    @(negedge clk); evt = '0;
  endtask

  function automatic bit filt(logic [1:0] p, logic v, logic [63:0] e);
    if (p == 2'b11) return e[62];
    if (p == 2'b01) return v ? e[59] : e[61];
    if (p == 2'b00) return v ? e[58] : e[60];
    return 0;
  endfunction

  task automatic t_reset;
    logic [63:0] v;
    for (int k = 3; k < 3 + NPROG; k++) begin
      rd(0, 5'(k), v); chk("R1 cnt", v, 0);
      rd(2, 5'(k), v); chk("R1 ev", v, 0);
    end
    rd(4, 0, v); chk("R1 inh", v, 0);
    rd(5, 0, v); chk("R1 pend", v, 0);
    chk("R1 irq", 64'(lcof_irq), 0);
  endtask

  task automatic t_basic;
    logic [63:0] v;
    for (int n = 0; n < 5; n++) pulse(n < 2 ? 4'b0011 : 4'b0001);
    rd(0, 3, v); chk("R2 ctr3", v, 5);
    rd(0, 4, v); chk("R2 ctr4", v, 2);
    rd(0, 5, v); chk("R2 ctr5 idle", v, 0);
    repeat (3) @(negedge clk);
    rd(0, 3, v); chk("R2 hold", v, 5);
  endtask

  task automatic t_filter;
    logic [63:0] v, e;
    logic [1:0] ps [3] = '{2'b11, 2'b01, 2'b00};
    for (int b = 58; b <= 62; b++)
      for (int m = 0; m < 3; m++)
        for (int vv = 0; vv < 2; vv++) begin
          e = 64'd1 << b;
          wr(0, 3, 0); wr(2, 3, e);
          priv = ps[m]; virt = vv[0];
          pulse(4'b0001);
          rd(0, 3, v);
          chk(vv ? "R5 virt filter" : "R4 mode filter", v, filt(ps[m], vv[0], e) ? 0 : 1);
        end
    priv = 2'b11; virt = 0;
    wr(2, 3, 0);
  endtask

  task automatic t_inhibit;
    logic [63:0] v;
    wr(0, 4, 0);
    wr(4, 0, 64'hFFFF_FFFF_FFFF_FFF0);
    rd(4, 0, v); chk("R3 inh readback", v, 64'h70);
    wr(4, 0, 64'h10);
    pulse(4'b0011);
    rd(0, 4, v); chk("R3 inhibited", v, 0);
    wr(4, 0, 0);
    pulse(4'b0010);
    rd(0, 4, v); chk("R3 released", v, 1);
  endtask

  task automatic t_wrap64;
    logic [63:0] v;
    wr(0, 3, ONES - 1);
    pulse(4'b0001);
    rd(0, 3, v); chk("R6 at ones", v, ONES);
    chk("R8 no irq yet", 64'(lcof_irq), 0);
    pulse(4'b0001);
    rd(0, 3, v); chk("R6 wrap", v, 0);
    chk("R8 irq", 64'(lcof_irq), 1);
    rd(2, 3, v); chk("R8 flag", v, 64'h8000_0000_0000_0000);
    rd(5, 0, v); chk("R8 pend bit", v, 64'h8);
    wr(5, 0, 64'h8);
    chk("R10 pend clear", 64'(lcof_irq), 0);
    rd(2, 3, v); chk("R10 flag kept", v, 64'h8000_0000_0000_0000);
    wr(0, 3, ONES);
    pulse(4'b0001);
    rd(0, 3, v); chk("R9 wraps", v, 0);
    chk("R9 no new irq", 64'(lcof_irq), 0);
    wr(2, 3, 0); wr(0, 3, ONES);
    pulse(4'b0001);
    chk("R10 irq after flag clear", 64'(lcof_irq), 1);
    wr(5, 0, 64'h8); wr(2, 3, 0);
  endtask

  task automatic t_half;
    logic [63:0] v;
    half_mode = 1;
    wr(0, 3, 64'hFFFF_FFFE); wr(1, 3, 0);
    pulse(4'b0001);
    rd(0, 3, v); chk("R7 lo ones", v, 64'hFFFF_FFFF);
    rd(1, 3, v); chk("R7 hi zero", v, 0);
    pulse(4'b0001);
    rd(0, 3, v); chk("R7 lo held", v, 64'hFFFF_FFFF);
    rd(1, 3, v); chk("R7 hi step", v, 1);
    wr(1, 3, 64'hFFFF_FFFF);
    pulse(4'b0001);
    rd(0, 3, v); chk("R7 lo wrap", v, 0);
    rd(1, 3, v); chk("R7 hi wrap", v, 0);
    chk("R8 irq half", 64'(lcof_irq), 1);
    rd(3, 3, v); chk("R13 flag in hi ev", v, 64'h8000_0000);
    rd(2, 3, v); chk("R13 lo ev clear", v, 0);
    wr(5, 0, 64'h8); wr(3, 3, 64'h4000_0000);
    pulse(4'b0001);
    rd(0, 3, v); chk("R13 hi M-inhibit", v, 0);
    wr(3, 3, 0);
    half_mode = 0;
    wr(1, 3, 64'h1234);
    rd(0, 3, v); chk("R13 hi write ignored 64", v, 0);
  endtask

  task automatic t_prio;
    logic [63:0] v;
    @(negedge clk);
    csr_we = 1; csr_sel = 0; csr_idx = 3; csr_wdata = 100; evt = 4'b0001;
    @(negedge clk);
    csr_we = 0; evt = 0;
    rd(0, 3, v); chk("R11 write wins", v, 100);
    @(negedge clk);
    csr_we = 1; csr_sel = 2; csr_idx = 3; csr_wdata = 0; evt = 4'b0001;
    @(negedge clk);
    csr_we = 0; evt = 0;
    rd(0, 3, v); chk("R11 ev write drops", v, 100);
  endtask

  task automatic t_range;
    logic [63:0] v;
    wr(0, 2, 64'h55); wr(0, 7, 64'h66); wr(2, 7, 64'h77);
    rd(0, 2, v); chk("R12 idx2 zero", v, 0);
    rd(0, 7, v); chk("R12 idx7 zero", v, 0);
    rd(2, 7, v); chk("R12 ev idx7 zero", v, 0);
    rd(0, 6, v); chk("R12 idx6 untouched", v, 0);
    wr(0, 6, 64'h99);
    rd(0, 6, v); chk("R12 idx6 valid", v, 64'h99);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset;
    t_basic;
    t_filter;
    t_inhibit;
    t_wrap64;
    t_half;
    t_prio;
    t_range;
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule